// File: doc/BRIEF.md
# I2C Single-Byte Register Target

This block is an I2C target that lets a host on a two-wire bus reach a small file of 8-bit registers. It oversamples SCL and SDA with the system clock. Each line goes through a synchronizer and a glitch filter. The block then detects start, repeated start and stop conditions and pulls SDA low through an open-drain enable. A write frame sets a register pointer and may store one data byte. A read frame returns one byte from the register that the pointer selects.

Toward the rest of the chip the block offers a plain register bus. A one-cycle write strobe carries the pointer and the data. A one-cycle read strobe marks the moment a byte is captured for transmission, so that side logic can clear status on read. A status byte input supplies the contents of the read-only status registers. The identifier register is a constant. The remaining addresses inside the storage depth are writable storage.

The system clock must run at least 16 times faster than SCL, so a 400 kHz bus needs at least 6.4 MHz.

Top module: `i2crf_target`

## Requirements
- R1: The target answers to 7-bit address 0x60. Address byte 0xC0 (write) and 0xC1 (read) are ACKed, meaning SDA is held low for the ninth clock of the byte. Pointer and data bytes of a write frame are ACKed too.
- R2: An address byte with any other 7-bit address is NACKed (SDA stays released). Until the next stop, the target then ignores the bus, including repeated starts, and raises no strobe.
- R3: In a write frame, the byte after the address byte sets the pointer and the next byte is stored. reg_wr_o pulses for one cycle with reg_addr_o equal to the pointer and reg_wdata_o equal to the data. Writable storage covers pointers 0x00 to 0x1F, with reset value 0x00. Pointers at or above 0x20 read 0x00.
- R4: Data bytes after the first one in a write frame are ACKed, but raise no strobe and change no register.
- R5: Pointer 0x00 reads the constant 0x15. A write to it is ACKed but raises no strobe and has no effect.
- R6: Pointers 0x02, 0x10 and 0x11 are read-only. Writes to them are ACKed but raise no strobe. Reads of them return stat_rdata_i.
- R7: A read frame returns the byte MSB first. SDA driven by the target changes only while SCL is low.
- R8: The pointer survives a stop condition. A read frame with no pointer byte returns the register addressed last.
- R9: reg_rd_o pulses for exactly one cycle for each byte the target transmits, and at no other time.
- R10: After reset and after any stop condition, SDA is released and both strobes are low.
- R11: A pulse lasting a single system-clock sample on SCL or on SDA is ignored and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed at the pad |
| sda_i | input | 1 | Bus data line as sensed at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_o | output | 1 | One-cycle write strobe toward side logic |
| reg_rd_o | output | 1 | One-cycle strobe when a byte is captured for transmit |
| reg_addr_o | output | 8 | Current register pointer |
| reg_wdata_o | output | 8 | Data byte accompanying reg_wr_o |
| stat_rdata_i | input | 8 | Contents returned for the read-only status pointers |

## Verification
A corrupted bit counter or phase register shows up at the ports within one byte. It produces either a missing or misplaced acknowledge, seen in the ninth clock of the byte in question, or a strobe that fires on a later byte than the first data byte. A wrong pointer only becomes visible at the next read frame, where the returned byte differs. For that reason every write is followed by a read-back, and the pointer is also checked after an intervening stop. The skip state is probed by sending a valid address after a repeated start inside an unmatched frame: an ACK there exposes a target that left the skip state too early.

// File: rtl/i2crf_pkg.sv
package i2crf_pkg;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CW = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_PTR,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        tgt_state_e      state;
        rx_phase_e       phase;
        logic [CW-1:0]   cnt;
        logic [DW-1:0]   sh;
        logic [AW-1:0]   ptr;
        logic            rw;
        logic            data_seen;
        logic            oe;
        logic            wr;
        logic            rd;
        logic [DW-1:0]   wdata;
    } tgt_regs_t;

endpackage

// File: rtl/i2crf_line_filter.sv
module i2crf_line_filter
    import i2crf_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic lvl;
    } flt_t;

    flt_t d, q;

    // two-flop synchronizer, then accept a level only after two equal samples
    always_comb begin
        d    = q;
        d.s1 = raw_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
        if (q.s2 == q.s3) begin
            d.lvl = q.s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s1: IDLE_LVL, s2: IDLE_LVL, s3: IDLE_LVL, lvl: IDLE_LVL};
        end else begin
            q <= d;
        end
    end

    assign lvl_o = q.lvl;

endmodule

// File: rtl/i2crf_edge_detect.sv
module i2crf_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t d, q;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_rise_o = !q.scl && scl_i;
    assign scl_fall_o = q.scl && !scl_i;
    // SDA moving while SCL stays high marks a bus condition
    assign start_o    = q.scl && scl_i && q.sda && !sda_i;
    assign stop_o     = q.scl && scl_i && !q.sda && sda_i;

endmodule

// File: rtl/i2crf_regbank.sv
module i2crf_regbank
    import i2crf_pkg::*;
#(
    parameter int            DEPTH   = 32,
    parameter logic [AW-1:0] ID_ADDR = 8'h00,
    parameter logic [DW-1:0] ID_VAL  = 8'h15,
    parameter logic [AW-1:0] STAT_A  = 8'h02,
    parameter logic [AW-1:0] STAT_B  = 8'h10,
    parameter logic [AW-1:0] STAT_C  = 8'h11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] stat_i,
    output logic [DW-1:0] rdata_o,
    output logic          wr_ok_o
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [DW-1:0]    mem_q [DEPTH];
    logic [DW-1:0]    mem_d [DEPTH];
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             is_stat;
    logic             is_id;

    assign idx      = addr_i[IDX_W-1:0];
    assign in_range = (addr_i >> IDX_W) == '0;
    assign is_id    = addr_i == ID_ADDR;
    assign is_stat  = (addr_i == STAT_A) || (addr_i == STAT_B) || (addr_i == STAT_C);
    assign wr_ok_o  = in_range && !is_id && !is_stat;

    always_comb begin
        mem_d = mem_q;
        if (wr_i && wr_ok_o) begin
            mem_d[idx] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        if (is_id) begin
            rdata_o = ID_VAL;
        end else if (is_stat) begin
            rdata_o = stat_i;
        end else if (in_range) begin
            rdata_o = mem_q[idx];
        end else begin
            rdata_o = '0;
        end
    end

endmodule

// File: rtl/i2crf_engine.sv
module i2crf_engine
    import i2crf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          wr_ok_i,
    output logic          oe_o,
    output logic          wr_o,
    output logic          rd_o,
    output logic [AW-1:0] ptr_o,
    output logic [DW-1:0] wdata_o
);

    localparam logic [CW-1:0] BITS = CW'(DW);

    tgt_regs_t d, q;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        d.rd = 1'b0;
        if (stop_i) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else if (start_i && q.state != ST_SKIP) begin
            d.state = ST_RX;
            d.phase = PH_DEV;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else begin
            case (q.state)
                ST_RX: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[DW-2:0], sda_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == BITS) begin
                        d.cnt = '0;
                        case (q.phase)
                            PH_DEV: begin
                                if (q.sh[DW-1:1] == DEV_ADDR) begin
                                    d.oe    = 1'b1;
                                    d.rw    = q.sh[0];
                                    d.state = ST_ACK;
                                end else begin
                                    d.state = ST_SKIP;
                                end
                            end
                            PH_PTR: begin
                                d.ptr       = q.sh;
                                d.data_seen = 1'b0;
                                d.oe        = 1'b1;
                                d.state     = ST_ACK;
                            end
                            default: begin
                                d.oe    = 1'b1;
                                d.state = ST_ACK;
                                if (!q.data_seen) begin
                                    d.data_seen = 1'b1;
                                    d.wr        = wr_ok_i;
                                    d.wdata     = q.sh;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        d.oe = 1'b0;
                        if (q.phase == PH_DEV && q.rw) begin
                            d.sh    = rdata_i;
                            d.rd    = 1'b1;
                            d.oe    = !rdata_i[DW-1];
                            d.cnt   = CW'(1);
                            d.state = ST_TX;
                        end else begin
                            d.state = ST_RX;
                            d.phase = (q.phase == PH_DEV) ? PH_PTR : PH_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (q.cnt == BITS) begin
                            d.oe    = 1'b0;
                            d.state = ST_MACK;
                        end else begin
                            d.sh  = {q.sh[DW-2:0], 1'b1};
                            d.oe  = !q.sh[DW-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_fall_i) begin
                        d.state = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, phase: PH_DEV, cnt: '0, sh: '0, ptr: '0,
                   rw: 1'b0, data_seen: 1'b0, oe: 1'b0, wr: 1'b0, rd: 1'b0,
                   wdata: '0};
        end else begin
            q <= d;
        end
    end

    assign oe_o    = q.oe;
    assign wr_o    = q.wr;
    assign rd_o    = q.rd;
    assign ptr_o   = q.ptr;
    assign wdata_o = q.wdata;

    AST_PULL_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_i); // R7
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr); // R3
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd |=> !q.rd); // R9
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SKIP) |-> (!q.oe && !q.wr && !q.rd)); // R2
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !q.oe); // R10

endmodule

// File: rtl/i2crf_target.sv
module i2crf_target
    import i2crf_pkg::*;
#(
    parameter logic [6:0]    DEV_ADDR = 7'h60,
    parameter int            DEPTH    = 32,
    parameter logic [DW-1:0] ID_VAL   = 8'h15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    output logic          reg_wr_o,
    output logic          reg_rd_o,
    output logic [AW-1:0] reg_addr_o,
    output logic [DW-1:0] reg_wdata_o,
    input  logic [DW-1:0] stat_rdata_i
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] filt;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic [DW-1:0]     rdata;
    logic              wr_ok;

    assign raw = {scl_i, sda_i};

    for (genvar k = 0; k < NLINES; k++) begin : g_line
        i2crf_line_filter #(.IDLE_LVL(1'b1)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw[k]),
            .lvl_o (filt[k])
        );
    end

    i2crf_edge_detect u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (filt[1]),
        .sda_i      (filt[0]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2crf_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (filt[1]),
        .sda_i      (filt[0]),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .rdata_i    (rdata),
        .wr_ok_i    (wr_ok),
        .oe_o       (sda_oe_o),
        .wr_o       (reg_wr_o),
        .rd_o       (reg_rd_o),
        .ptr_o      (reg_addr_o),
        .wdata_o    (reg_wdata_o)
    );

    i2crf_regbank #(.DEPTH(DEPTH), .ID_VAL(ID_VAL)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_o),
        .wr_i    (reg_wr_o),
        .wdata_i (reg_wdata_o),
        .stat_i  (stat_rdata_i),
        .rdata_o (rdata),
        .wr_ok_o (wr_ok)
    );

endmodule

// File: tb/i2crf_target_test.sv
module i2crf_target_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_addr, reg_wdata;
    logic [7:0] stat_val = 8'h00;

    int vectors = 0;
    int miscompares = 0;
    int rd_seen = 0;
    int rd_expected = 0;
    bit done = 0;
    logic [15:0] exp_wr_q[$];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2crf_target uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .reg_wr_o     (reg_wr),
        .reg_rd_o     (reg_rd),
        .reg_addr_o   (reg_addr),
        .reg_wdata_o  (reg_wdata),
        .stat_rdata_i (stat_val)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: every write strobe must match the next expected item
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            vectors++;
            if (exp_wr_q.size() == 0) begin
                miscompares++;
                $display("FAIL R4 R5 R6 unexpected strobe actual=%h expected=none",
                         {reg_addr, reg_wdata});
            end else begin
                logic [15:0] e;
                e = exp_wr_q.pop_front();
                if ({reg_addr, reg_wdata} !== e) begin
                    miscompares++;
                    $display("FAIL R3 write strobe actual=%h expected=%h",
                             {reg_addr, reg_wdata}, e);
                end
            end
        end
        if (rst_n && reg_rd) rd_seen++;
    end

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            if (glitch && i == 3) begin
                sda_m = ~b[i]; tick(1);
                sda_m = b[i];
            end
            tick(Q);
            scl_m = 1'b0;
            if (glitch && i == 4) begin
                tick(3); scl_m = 1'b1; tick(1); scl_m = 1'b0;
            end
            tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, output bit steady);
        logic first;
        steady = 1'b1;
        sda_m  = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(1);
            first = sda_line; tick(Q - 1);
            b[i] = sda_line; tick(Q - 2);
            if (sda_line !== first) steady = 1'b0;
            scl_m = 1'b0; tick(Q);
        end
        tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_frame(input string tag, input logic [7:0] a,
                               input logic [7:0] d0, input logic [7:0] d1,
                               input logic [7:0] d2, input int n, input bit glitch);
        bit ak;
        bus_start();
        send_byte(8'hC0, 1'b0, ak); chk({tag, " R1 addr ack"}, 16'(ak), 16'd1);
        send_byte(a, 1'b0, ak);     chk({tag, " R1 ptr ack"}, 16'(ak), 16'd1);
        if (n > 0) begin send_byte(d0, glitch, ak); chk({tag, " R1 data ack"}, 16'(ak), 16'd1); end
        if (n > 1) begin send_byte(d1, 1'b0, ak); chk({tag, " R4 extra ack"}, 16'(ak), 16'd1); end
        if (n > 2) begin send_byte(d2, 1'b0, ak); chk({tag, " R4 extra ack"}, 16'(ak), 16'd1); end
        bus_stop();
        chk({tag, " R10 released after stop"}, 16'(sda_oe), 16'd0);
    endtask

    task automatic read_frame(input string tag, input logic [7:0] a, input logic [7:0] exp);
        bit ak, st;
        logic [7:0] b;
        bus_start();
        send_byte(8'hC0, 1'b0, ak);
        send_byte(a, 1'b0, ak);
        bus_rstart();
        send_byte(8'hC1, 1'b0, ak); chk({tag, " R1 read addr ack"}, 16'(ak), 16'd1);
        recv_byte(b, st);
        rd_expected++;
        chk({tag, " R7 stable while SCL high"}, 16'(st), 16'd1);
        chk({tag, " read data"}, 16'(b), 16'(exp));
        bus_stop();
    endtask

    initial begin
        bit ak, st;
        logic [7:0] b;
        tick(5);
        chk("R10 reset oe", 16'(sda_oe), 16'd0);
        chk("R10 reset strobes", {14'd0, reg_wr, reg_rd}, 16'd0);
        rst_n = 1'b1;
        tick(5);

        // R3 basic write and read back
        exp_wr_q.push_back({8'h05, 8'hA5});
        write_frame("R3 wr05", 8'h05, 8'hA5, 8'h00, 8'h00, 1, 1'b0);
        read_frame("R3 rd05", 8'h05, 8'hA5);

        // R4 only the first data byte is kept
        exp_wr_q.push_back({8'h06, 8'h3C});
        write_frame("R4 wr06", 8'h06, 8'h3C, 8'h77, 8'h99, 3, 1'b0);
        read_frame("R4 rd06", 8'h06, 8'h3C);

        // R5 identifier constant and write-protected
        read_frame("R5 rd00", 8'h00, 8'h15);
        write_frame("R5 wr00", 8'h00, 8'hFF, 8'h00, 8'h00, 1, 1'b0);
        read_frame("R5 rd00 after write", 8'h00, 8'h15);

        // R6 status pointers
        stat_val = 8'h5A;
        write_frame("R6 wr10", 8'h10, 8'h01, 8'h00, 8'h00, 1, 1'b0);
        write_frame("R6 wr02", 8'h02, 8'h02, 8'h00, 8'h00, 1, 1'b0);
        read_frame("R6 rd10", 8'h10, 8'h5A);
        stat_val = 8'hC6;
        read_frame("R6 rd11", 8'h11, 8'hC6);
        read_frame("R6 rd02", 8'h02, 8'hC6);

        // R3 out-of-range pointer reads zero
        read_frame("R3 rd40", 8'h40, 8'h00);

        // R8 pointer survives a stop
        write_frame("R8 ptr only", 8'h05, 8'h00, 8'h00, 8'h00, 0, 1'b0);
        bus_start();
        send_byte(8'hC1, 1'b0, ak); chk("R8 R1 bare read ack", 16'(ak), 16'd1);
        recv_byte(b, st);
        rd_expected++;
        chk("R8 R7 bare read data", 16'(b), 16'hA5);
        bus_stop();

        // R2 foreign address, then repeated start inside the skipped frame
        bus_start();
        send_byte(8'hA0, 1'b0, ak); chk("R2 foreign addr nack", 16'(ak), 16'd0);
        send_byte(8'h07, 1'b0, ak); chk("R2 byte after nack", 16'(ak), 16'd0);
        bus_rstart();
        send_byte(8'hC0, 1'b0, ak); chk("R2 start ignored until stop", 16'(ak), 16'd0);
        send_byte(8'h07, 1'b0, ak);
        send_byte(8'h11, 1'b0, ak);
        bus_stop();
        read_frame("R2 rd07 unchanged", 8'h07, 8'h00);

        // R11 single-sample glitches on SCL and SDA
        exp_wr_q.push_back({8'h08, 8'hC3});
        write_frame("R11 wr08 glitched", 8'h08, 8'hC3, 8'h00, 8'h00, 1, 1'b1);
        read_frame("R11 rd08", 8'h08, 8'hC3);

        tick(20);
        chk("R9 read strobe count", 16'(rd_seen), 16'(rd_expected));
        chk("R3 R4 pending writes", 16'(exp_wr_q.size()), 16'd0);
        chk("R10 idle oe", 16'(sda_oe), 16'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule